// File: doc/BRIEF.md
# Burst Column Sequencer

This block is the column address counter inside a synchronous DRAM model. When a read or write command arrives, it captures the starting column and the current burst mode. From the next clock on it presents one column address per cycle until the burst is complete. A burst-stop strobe or a fresh column command can cut the burst short on any cycle. The burst mode is held in a small register that is loaded from a 3-bit length code and a one-bit ordering select. Codes that cannot be honoured raise an error flag, and while that flag is set no burst is started.

The column stream has no back-pressure. The receiving logic must accept one address in every cycle in which `col_valid` is high, and the sequence never waits. Command and mode inputs are single-cycle strobes sampled on the rising clock edge. When a command and a stop arrive in the same cycle, the command wins. The counter takes a copy of the mode at the start of each burst, so loading a new mode in the middle of a burst affects only the bursts that follow.

Top module: `burst_col_seq`

## Requirements
- R1: The length code selects the burst length as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. `mode_interleave`=0 selects sequential order and 1 selects interleaved order.
- R2: One cycle after a mode load, `mode_err` is 1 if the code is 3'b100, 3'b101 or 3'b110, or if the code is 3'b111 with interleave selected. After a load of any other combination it is 0.
- R3: A `cmd_go` with a valid mode makes `col_valid` rise on the next cycle with `col` equal to `cmd_col`. After that, one beat is presented in each cycle.
- R4: In sequential order with length BL, beat i has its low log2(BL) bits equal to (start+i) mod BL. The upper bits stay equal to those of the start column.
- R5: In interleaved order with length BL, beat i has its low log2(BL) bits equal to the start's low bits XOR i. The upper bits stay fixed.
- R6: `col_last` is 1 only on beat BL-1 of a fixed-length burst. If no new command arrives, `col_valid` is 0 on the cycle after that beat.
- R7: A full-page burst presents (start+i) mod 2^COL_W, wraps past the top column, continues until it is stopped or interrupted, and never raises `col_last`.
- R8: A `cmd_stop` without `cmd_go` makes `col_valid` 0 from the next cycle. If `cmd_go` is high in the same cycle, the new burst starts instead.
- R9: A `cmd_go` during a burst restarts the sequence at beat 0 of the new column on the next cycle. This works on any beat, including on consecutive cycles.
- R10: A `cmd_go` while `mode_err` is 1 starts no burst and ends any burst in progress, so `col_valid` is 0 on the next cycle.
- R11: A mode load during a burst does not change the length or order of that burst.
- R12: During and after reset, `col_valid`, `col_last` and `mode_err` are 0 and the mode is 1-beat sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Strobe that loads the burst mode |
| mode_len_code | input | 3 | Burst length code |
| mode_interleave | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| cmd_go | input | 1 | Read/write column command strobe (starts or interrupts a burst) |
| cmd_col | input | COL_W | Starting column of the command |
| cmd_stop | input | 1 | Burst-stop strobe |
| col | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Loaded mode is reserved; bursts are suppressed |

## Verification
The bench builds the block with the default COL_W of 8. At that width every start column can be swept for every fixed length in both orders, so the wrap within the length-aligned group is exercised at each position, and so is the full-page wrap past column 255. Full-page bursts run for more than 256 beats from several starts. Directed sequences then cover stop, interrupts on consecutive cycles, a stop arriving together with a command, reserved codes and a mode change in the middle of a burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int LEN_CODE_W = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  interleave,
  output logic [COL_W-1:0]      mode_mask,
  output logic                  mode_il,
  output logic                  mode_page,
  output logic                  mode_ok,
  output logic                  mode_err
);
  logic [COL_W-1:0] nxt_mask;
  logic             nxt_page;
  logic             nxt_bad;
  logic             err_q;

  always_comb begin
    nxt_mask = '0;
    nxt_page = 1'b0;
    nxt_bad  = 1'b0;
    case (len_code_e'(len_code))
      LEN_1:    nxt_mask = '0;
      LEN_2:    nxt_mask = COL_W'(1);
      LEN_4:    nxt_mask = COL_W'(3);
      LEN_8:    nxt_mask = COL_W'(7);
      LEN_PAGE: begin
        nxt_mask = '1;
        nxt_page = 1'b1;
        nxt_bad  = interleave;
      end
      default:  nxt_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_mask <= '0;
      mode_il   <= 1'b0;
      mode_page <= 1'b0;
      err_q     <= 1'b0;
    end else if (load) begin
      mode_mask <= nxt_mask;
      mode_il   <= interleave;
      mode_page <= nxt_page;
      err_q     <= nxt_bad;
    end
  end

  assign mode_err = err_q;
  assign mode_ok  = !err_q;

  a_r2_reserved_len: assert property (@(posedge clk) disable iff (!rst_n)
    load && len_code[2] && (len_code != 3'b111) |=> mode_err);
  a_r2_page_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    load && (len_code == 3'b111) && interleave |=> mode_err);
  a_r2_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load && !len_code[2] |=> !mode_err);
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic [COL_W-1:0] go_col,
  input  logic             mode_ok,
  input  logic [COL_W-1:0] mode_mask,
  input  logic             mode_il,
  input  logic             mode_page,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] mask,
  output logic             il,
  output logic             last
);
  logic page;

  assign last = active && !page && (idx == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      idx    <= '0;
      mask   <= '0;
      il     <= 1'b0;
      page   <= 1'b0;
    end else if (go) begin
      active <= mode_ok;
      base   <= go_col;
      idx    <= '0;
      mask   <= mode_mask;
      il     <= mode_il;
      page   <= mode_page;
    end else if (halt) begin
      active <= 1'b0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end

  a_r8_halt_ends: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !go |=> !active);
  a_r9_restart_index: assert property (@(posedge clk) disable iff (!rst_n)
    go && mode_ok |=> active && (idx == '0));
  a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active && !page |-> ((idx & ~mask) == '0));
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             il,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;

  assign sum = base + idx;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? (il ? (base[b] ^ idx[b]) : sum[b]) : base[b];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [2:0]       mode_len_code,
  input  logic             mode_interleave,
  input  logic             cmd_go,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_stop,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err
);
  logic [COL_W-1:0] m_mask;
  logic             m_il;
  logic             m_page;
  logic             m_ok;
  logic [COL_W-1:0] b_base;
  logic [COL_W-1:0] b_idx;
  logic [COL_W-1:0] b_mask;
  logic             b_il;

  bcs_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (mode_load),
    .len_code   (mode_len_code),
    .interleave (mode_interleave),
    .mode_mask  (m_mask),
    .mode_il    (m_il),
    .mode_page  (m_page),
    .mode_ok    (m_ok),
    .mode_err   (mode_err)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (cmd_go),
    .halt      (cmd_stop),
    .go_col    (cmd_col),
    .mode_ok   (m_ok),
    .mode_mask (m_mask),
    .mode_il   (m_il),
    .mode_page (m_page),
    .active    (col_valid),
    .base      (b_base),
    .idx       (b_idx),
    .mask      (b_mask),
    .il        (b_il),
    .last      (col_last)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base (b_base),
    .idx  (b_idx),
    .mask (b_mask),
    .il   (b_il),
    .col  (col)
  );

  a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && !mode_err |=> col_valid && (col == $past(cmd_col)));
  a_r10_bad_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && mode_err |=> !col_valid);
  a_r6_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
  a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    col_last && !cmd_go |=> !col_valid);
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !cmd_go && !cmd_stop |=>
      col_valid && (((col ^ $past(col)) & ~b_mask) == '0));
  a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !cmd_go && !cmd_stop && !b_il |=>
      (((col - $past(col)) & b_mask) == COL_W'(1)));
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_load;
  logic [2:0] mode_len_code;
  logic       mode_interleave;
  logic       cmd_go;
  logic [7:0] cmd_col;
  logic       cmd_stop;
  logic [7:0] col;
  logic       col_valid;
  logic       col_last;
  logic       mode_err;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len_code(mode_len_code),
    .mode_interleave(mode_interleave), .cmd_go(cmd_go), .cmd_col(cmd_col),
    .cmd_stop(cmd_stop), .col(col), .col_valid(col_valid), .col_last(col_last),
    .mode_err(mode_err)
  );

  function automatic logic [7:0] exp_col(input int s, input int i, input int bl, input bit il);
    int m;
    int lo;
    m  = bl - 1;
    lo = il ? ((s ^ i) & m) : ((s + i) & m);
    return 8'((s & ~m & 255) | lo);
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic chk_beat(input logic [7:0] ec, input bit el, input string req);
    chk(col_valid === 1'b1, {req, " valid"}, int'(col_valid), 1);
    chk(col === ec, {req, " column"}, int'(col), int'(ec));
    chk(col_last === el, "R6 last flag", int'(col_last), int'(el));
  endtask

  task automatic chk_idle(input string req);
    chk(col_valid === 1'b0, {req, " idle"}, int'(col_valid), 0);
  endtask

  task automatic load_mode(input logic [2:0] code, input bit il);
    @(negedge clk);
    mode_load = 1'b1; mode_len_code = code; mode_interleave = il;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic run_burst(input int s, input int bl, input bit il, input bit page, input string req);
    int nb;
    nb = page ? 300 : bl;
    @(negedge clk);
    cmd_go = 1'b1; cmd_col = 8'(s);
    @(negedge clk);
    cmd_go = 1'b0;
    for (int i = 0; i < nb; i++) begin
      chk_beat(exp_col(s, i, bl, il), !page && (i == bl - 1), req);
      @(negedge clk);
    end
    if (page) begin
      cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
      chk_idle("R8 stop after page");
    end else begin
      chk_idle("R6 end of burst");
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_len_code = 3'b000; mode_interleave = 1'b0;
    cmd_go = 1'b0; cmd_col = 8'h00; cmd_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk(col_valid === 1'b0, "R12 valid in reset", int'(col_valid), 0);
    chk(mode_err === 1'b0, "R12 err in reset", int'(mode_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_last === 1'b0, "R12 last after reset", int'(col_last), 0);
    // R12: default mode is single beat sequential
    run_burst(8'hA5, 1, 1'b0, 1'b0, "R12 default mode");

    // R1 R4 R5 R6: every fixed length, both orders, every start column
    for (int code = 0; code < 4; code++) begin
      for (int il = 0; il < 2; il++) begin
        load_mode(3'(code), il[0]);
        chk(mode_err === 1'b0, "R2 valid code", int'(mode_err), 0);
        for (int s = 0; s < 256; s++)
          run_burst(s, 1 << code, il[0], 1'b0, il ? "R1 R5 interleave" : "R1 R4 sequential");
      end
    end

    // R7: full page wraps and never flags last
    load_mode(3'b111, 1'b0);
    chk(mode_err === 1'b0, "R2 page sequential", int'(mode_err), 0);
    for (int s = 0; s < 256; s += 37) run_burst(s, 256, 1'b0, 1'b1, "R7 full page");

    // R8: stop mid burst, then go and stop together
    load_mode(3'b010, 1'b0);
    @(negedge clk); cmd_go = 1'b1; cmd_col = 8'h20;
    @(negedge clk); cmd_go = 1'b0;
    chk_beat(8'h20, 1'b0, "R8 before stop");
    @(negedge clk);
    chk_beat(8'h21, 1'b0, "R8 before stop");
    cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    chk_idle("R8 stop");
    @(negedge clk);
    chk_idle("R8 stays stopped");
    cmd_go = 1'b1; cmd_stop = 1'b1; cmd_col = 8'h32;
    @(negedge clk); cmd_go = 1'b0; cmd_stop = 1'b0;
    chk_beat(8'h32, 1'b0, "R8 go wins over stop");
    @(negedge clk);
    chk_beat(8'h33, 1'b0, "R8 go wins over stop");
    repeat (4) @(negedge clk);

    // R9: interrupt mid burst and on consecutive cycles
    load_mode(3'b011, 1'b0);
    @(negedge clk); cmd_go = 1'b1; cmd_col = 8'h10;
    @(negedge clk); cmd_col = 8'h00; cmd_go = 1'b0;
    chk_beat(8'h10, 1'b0, "R9 first burst");
    @(negedge clk);
    chk_beat(8'h11, 1'b0, "R9 first burst");
    cmd_go = 1'b1; cmd_col = 8'h35;
    @(negedge clk);
    chk_beat(8'h35, 1'b0, "R9 interrupt");
    cmd_col = 8'h8E;
    @(negedge clk); cmd_go = 1'b0;
    chk_beat(8'h8E, 1'b0, "R9 consecutive");
    @(negedge clk);
    chk_beat(8'h8F, 1'b0, "R9 consecutive");
    @(negedge clk);
    chk_beat(8'h88, 1'b0, "R9 wrap in group");
    repeat (8) @(negedge clk);
    chk_idle("R9 burst ended");

    // R11: mode change during a burst leaves it unchanged
    @(negedge clk); cmd_go = 1'b1; cmd_col = 8'h45;
    @(negedge clk); cmd_go = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk_beat(exp_col(8'h45, i, 8, 1'b0), i == 7, "R11 snapshot");
      if (i == 0) begin mode_load = 1'b1; mode_len_code = 3'b001; mode_interleave = 1'b1; end
      else mode_load = 1'b0;
      @(negedge clk);
    end
    chk_idle("R11 end");
    run_burst(8'h45, 2, 1'b1, 1'b0, "R11 new mode applies");

    // R2 R10: reserved codes
    for (int code = 4; code < 7; code++) begin
      load_mode(3'(code), 1'b0);
      chk(mode_err === 1'b1, "R2 reserved code", int'(mode_err), 1);
      @(negedge clk); cmd_go = 1'b1; cmd_col = 8'h12;
      @(negedge clk); cmd_go = 1'b0;
      chk_idle("R10 no burst");
    end
    load_mode(3'b111, 1'b1);
    chk(mode_err === 1'b1, "R2 page interleave", int'(mode_err), 1);
    load_mode(3'b011, 1'b1);
    chk(mode_err === 1'b0, "R2 cleared", int'(mode_err), 0);
    @(negedge clk); cmd_go = 1'b1; cmd_col = 8'h03;
    @(negedge clk); cmd_go = 1'b0;
    chk_beat(8'h03, 1'b0, "R10 running");
    mode_load = 1'b1; mode_len_code = 3'b110;
    @(negedge clk); mode_load = 1'b0;
    chk_beat(8'h02, 1'b0, "R10 running");
    cmd_go = 1'b1; cmd_col = 8'h50;
    @(negedge clk); cmd_go = 1'b0;
    chk_idle("R10 go with bad mode ends burst");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule